// File: doc/BRIEF.md
# Eight-Mode 16 KB RAM Bank Mapper

This block sits between an 8-bit processor with a 16-bit address bus and a 128 KB RAM built from eight 16 KB pages. The CPU address space is cut into four 16 KB slots. A small configuration register chooses one of eight fixed slot-to-page arrangements. The block turns each CPU address into a 17-bit physical address: the slot picks a page through the current arrangement, and the low 14 address bits give the offset inside that page.

Software changes the arrangement with an I/O write. The upper byte of the I/O address must equal the mapper's select value, and the data byte carries a fixed prefix with the mode number in its three lowest bits. A second address path serves the video fetch unit. It always reads the lower 64 KB (pages 0 to 3) directly and never depends on the mode. The CPU and the video unit can therefore reach the same byte through different addresses. For example, a buffer the CPU sees at 0x4000 can sit at 0xC000 for the display.

Top module: `ram_bank_mapper`

## Requirements
- R1: While reset is active, the mode register returns to mode 0. The CPU path is then linear: CPU 0xC000 maps to physical 0x0C000.
- R2: A configuration write is taken at a rising clock edge when io_wr is 1, io_hi equals 0x7F and io_data[7:3] equals 5'b11000. The mode number is io_data[2:0].
- R3: A write with io_wr at 0, with io_hi other than 0x7F, or with io_data[7:3] other than 5'b11000 leaves the mode unchanged.
- R4: In mode 0, slots 0, 1, 2 and 3 (CPU 0x0000, 0x4000, 0x8000, 0xC000) map to pages 0, 1, 2 and 3.
- R5: In mode 1, the slots map to pages 0, 1, 2 and 7.
- R6: In mode 2, the slots map to pages 4, 5, 6 and 7.
- R7: In mode 3, the slots map to pages 0, 3, 2 and 7. Page 7 at slot 3 is common to modes 1, 2 and 3.
- R8: In modes 4 to 7, slots 0, 2 and 3 map to pages 0, 2 and 3, and slot 1 maps to the page equal to the mode number. The same CPU address 0x4000 therefore reaches four distinct physical addresses across these modes.
- R9: cpu_phys is {page, cpu_addr[13:0]}, formed with no register in the path.
- R10: vid_phys is {1'b0, vid_addr} in every mode.
- R11: A new mode applies to the CPU path from the clock edge that takes the write. Before that edge, the old mapping is still in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, sampled at the rising edge |
| io_hi | input | 8 | Upper byte of the I/O address |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU memory address |
| cpu_phys | output | 17 | Physical RAM address for the CPU access |
| vid_addr | input | 16 | Video fetch address |
| vid_phys | output | 17 | Physical RAM address for the video fetch |

## Verification
The bench builds the block with its default parameters: select byte 0x7F, data prefix 5'b11000, a 16-bit CPU address and four slots of eight possible pages. With these values, all eight modes and all four slots of each mode can be reached in a short run. The bench walks the whole 32-entry slot map. It then probes each field that decides whether a write is taken, the edge at which a new mode appears, and the video path, which must stay put while the CPU mapping moves.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    localparam int SLOT_W   = 2;
    localparam int PAGE_W   = 3;
    localparam int OFS_W    = 14;
    localparam int NUM_SLOT = 1 << SLOT_W;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [2:0] {
        MAP_LINEAR  = 3'd0,
        MAP_TOP7    = 3'd1,
        MAP_EXT_ALL = 3'd2,
        MAP_SWAP3   = 3'd3,
        MAP_WIN4    = 3'd4,
        MAP_WIN5    = 3'd5,
        MAP_WIN6    = 3'd6,
        MAP_WIN7    = 3'd7
    } map_mode_t;

    typedef struct packed {
        logic      take;
        map_mode_t mode;
    } cfg_wr_t;

    // Page reached by a CPU slot under a given mode.
    function automatic page_t slot_page(map_mode_t m, slot_t s);
        page_t p;
        p = page_t'(s);
        case (m)
            MAP_LINEAR:  p = page_t'(s);
            MAP_TOP7:    if (s == 2'd3) p = 3'd7;
            MAP_EXT_ALL: p = {1'b1, s};
            MAP_SWAP3: begin
                if (s == 2'd1) p = 3'd3;
                if (s == 2'd3) p = 3'd7;
            end
            default:     if (s == 2'd1) p = page_t'(m);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bank_io_decode.sv
module bank_io_decode
    import bank_map_pkg::*;
#(
    parameter logic [7:0] IO_SEL     = 8'h7F,
    parameter logic [4:0] CMD_PREFIX = 5'b11000
) (
    input  logic       io_wr,
    input  logic [7:0] io_hi,
    input  logic [7:0] io_data,
    output cfg_wr_t    req
);
    always_comb begin
        req.take = io_wr && (io_hi == IO_SEL) && (io_data[7:3] == CMD_PREFIX);
        req.mode = map_mode_t'(io_data[2:0]);
    end
endmodule

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg
    import bank_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cfg_wr_t   req,
    output map_mode_t mode
);
    always_ff @(posedge clk) begin
        if (rst)           mode <= MAP_LINEAR;
        else if (req.take) mode <= req.mode;
    end

    a_r1_reset_linear: assert property (@(posedge clk) rst |=> mode == MAP_LINEAR);
    a_r2_load_mode:    assert property (@(posedge clk) disable iff (rst)
                           req.take |=> mode == $past(req.mode));
    a_r3_hold_mode:    assert property (@(posedge clk) disable iff (rst)
                           !req.take |=> $stable(mode));
endmodule

// File: rtl/bank_cpu_xlate.sv
module bank_cpu_xlate
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  map_mode_t          mode,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic [ADDR_W:0]    cpu_phys
);
    localparam int OW = ADDR_W - SLOT_W;

    page_t slot_pg [NUM_SLOT];

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        assign slot_pg[s] = slot_page(mode, slot_t'(s));
    end

    always_comb begin
        cpu_phys = {slot_pg[cpu_addr[ADDR_W-1 -: SLOT_W]], cpu_addr[OW-1:0]};
    end
endmodule

// File: rtl/ram_bank_mapper.sv
module ram_bank_mapper
    import bank_map_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter logic [7:0] IO_SEL     = 8'h7F,
    parameter logic [4:0] CMD_PREFIX = 5'b11000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [7:0]        io_hi,
    input  logic [7:0]        io_data,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W:0]   cpu_phys,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [ADDR_W:0]   vid_phys
);
    localparam int OW = ADDR_W - SLOT_W;

    cfg_wr_t   req;
    map_mode_t mode;

    bank_io_decode #(.IO_SEL(IO_SEL), .CMD_PREFIX(CMD_PREFIX)) u_dec (
        .io_wr(io_wr), .io_hi(io_hi), .io_data(io_data), .req(req)
    );

    bank_cfg_reg u_cfg (.clk(clk), .rst(rst), .req(req), .mode(mode));

    bank_cpu_xlate #(.ADDR_W(ADDR_W)) u_xl (
        .mode(mode), .cpu_addr(cpu_addr), .cpu_phys(cpu_phys)
    );

    // Video fetch always lands in the lower half, independent of mode.
    assign vid_phys = {1'b0, vid_addr};

    a_r9_offset_pass: assert property (@(posedge clk) disable iff (rst)
        cpu_phys[OW-1:0] == cpu_addr[OW-1:0]);
    a_r7_common_top:  assert property (@(posedge clk) disable iff (rst)
        ((mode == MAP_TOP7 || mode == MAP_EXT_ALL || mode == MAP_SWAP3) &&
         cpu_addr[ADDR_W-1 -: SLOT_W] == '1) |-> cpu_phys[ADDR_W -: 3] == 3'd7);
    a_r10_video_match: assert property (@(posedge clk) disable iff (rst)
        (mode == MAP_LINEAR && cpu_addr == vid_addr) |-> cpu_phys == vid_phys);
endmodule

// File: tb/ram_bank_mapper_tb.sv
module ram_bank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [7:0]  io_hi;
    logic [7:0]  io_data;
    logic [15:0] cpu_addr;
    logic [16:0] cpu_phys;
    logic [15:0] vid_addr;
    logic [16:0] vid_phys;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ram_bank_mapper u_dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_hi(io_hi), .io_data(io_data),
        .cpu_addr(cpu_addr), .cpu_phys(cpu_phys),
        .vid_addr(vid_addr), .vid_phys(vid_phys)
    );

    // Per mode: pages of slots 0..3 as octal digits, slot 0 leftmost.
    localparam logic [11:0] MAP_TBL [8] = '{
        12'o0123, 12'o0127, 12'o4567, 12'o0327,
        12'o0423, 12'o0523, 12'o0623, 12'o0723
    };
    localparam string MODE_REQ [8] = '{"R4", "R5", "R6", "R7", "R8", "R8", "R8", "R8"};

    task automatic chk(input logic [16:0] act, input logic [16:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%05h expected 0x%05h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] hi, input logic [7:0] d, input logic wr);
        @(negedge clk);
        io_wr = wr; io_hi = hi; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [16:0] exp, input string req);
        cpu_addr = a;
        #1;
        chk(cpu_phys, exp, req);
    endtask

    initial begin
        rst = 1'b1; io_wr = 1'b0; io_hi = 8'h00; io_data = 8'h00;
        cpu_addr = 16'h0000; vid_addr = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state is linear
        probe(16'hC000, 17'h0C000, "R1");
        probe(16'h4123, 17'h04123, "R1");

        // R2/R4-R9: walk every mode and slot
        for (int m = 0; m < 8; m++) begin
            io_write(8'h7F, 8'hC0 | 8'(m), 1'b1);
            for (int s = 0; s < 4; s++) begin
                logic [2:0]  pg;
                logic [13:0] ofs;
                pg  = MAP_TBL[m][11 - 3*s -: 3];
                ofs = 14'(16'h0ABC + 16'(s * 16'h1111) + 16'(m));
                probe({2'(s), ofs}, {pg, ofs}, MODE_REQ[m]);
            end
        end

        // R8: slot 1 in modes 4..7 lands on four distinct pages
        for (int m = 4; m < 8; m++) begin
            io_write(8'h7F, 8'hC0 | 8'(m), 1'b1);
            probe(16'h4000, {3'(m), 14'h0000}, "R8");
        end

        // R3: rejected writes, mode 2 as baseline (slot 0 -> 0x10000)
        io_write(8'h7F, 8'hC2, 1'b1);
        io_write(8'h7E, 8'hC1, 1'b1);
        probe(16'h0000, 17'h10000, "R3 wrong select");
        io_write(8'h7F, 8'h81, 1'b1);
        probe(16'h0000, 17'h10000, "R3 bit6 clear");
        io_write(8'h7F, 8'h41, 1'b1);
        probe(16'h0000, 17'h10000, "R3 bit7 clear");
        io_write(8'h7F, 8'hC9, 1'b1);
        probe(16'h0000, 17'h10000, "R3 bit3 set");
        io_write(8'h7F, 8'hC1, 1'b0);
        probe(16'h0000, 17'h10000, "R3 no strobe");

        // R11: mode switch timing
        @(negedge clk);
        io_wr = 1'b1; io_hi = 8'h7F; io_data = 8'hC3;
        probe(16'h4000, 17'h14000, "R11 before edge");
        @(negedge clk);
        io_wr = 1'b0;
        probe(16'h4000, 17'h0C000, "R11 after edge");

        // R10: video path ignores mode 3, sees CPU 0x4000 byte at 0xC000
        vid_addr = 16'hC000;
        #1;
        chk(vid_phys, 17'h0C000, "R10 mode3");
        chk(vid_phys, cpu_phys, "R10 shared byte");
        io_write(8'h7F, 8'hC6, 1'b1);
        vid_addr = 16'h4321;
        #1;
        chk(vid_phys, 17'h04321, "R10 mode6");

        // R1: mid-run reset returns to linear
        io_write(8'h7F, 8'hC5, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        probe(16'h4000, 17'h04000, "R1 mid-run");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule